// File: doc/BRIEF.md
# Interrupt Dispatch Unit

This block decides, every clock cycle, whether one of the processor's interrupt request lines should be taken. It also picks which line is served and computes where the handler lives. The request lines are qualified by three things: a per-line block bit (a 1 suppresses the line), a global permit bit, and two "already in a handler" level bits. Among the surviving lines, the highest-numbered one is served.

The address of the handler comes from one of three dispatch styles, chosen at run time by a two-bit mode input:
- **Single:** one common entry point for everything.
- **Vectored:** a separate entry for each line, spaced at a fixed stride.
- **Table:** a pointer is fetched from a table of word-sized entries in memory. The block issues a one-cycle read request and waits for the memory's valid response. It then redirects to the returned pointer.

Each accepted interrupt produces exactly one single-cycle take strobe, together with the line number and the redirect address. The consumer is expected to raise the exception level in response, which stops further takes.

Top module: `irq_dispatch_unit`

## Requirements
- R1: A line whose block bit in `blk_mask_i` is 1 is never taken. A line whose block bit is 0 is eligible when the gates of R2 and R3 are open.
- R2: While `glob_en_i` is 0, no take strobe and no table read start.
- R3: While `exc_lvl_i` or `err_lvl_i` is 1, no take strobe and no table read start.
- R4: When several lines are eligible, `take_num_o` is the highest-numbered eligible line.
- R5: With mode code 0 (single), the redirect address is 0x8000_0180 for every line.
- R6: With mode code 1 (vectored), the redirect address for line n is 0x8000_0000 + 0x100*(n+1). So line 1 maps to 0x8000_0200 and line 2 maps to 0x8000_0300.
- R7: With mode code 2 (table), the block raises `ptr_rd_o` for exactly one cycle, with `ptr_addr_o` = 0x0000_0000 + 4*(n+1). It then asserts no take until `ptr_valid_i` is seen high at a clock edge. The take follows in the next cycle with `redirect_o` equal to `ptr_data_i`.
- R8: `take_o` is high for exactly one cycle per accepted interrupt. It is never high in two consecutive cycles, even when a request stays asserted.
- R9: In single and vectored modes, `take_o` rises at the first clock edge that samples an eligible line.
- R10: During and right after reset, `take_o` and `ptr_rd_o` are 0.
- R11: Mode code 3 behaves like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 8 | Interrupt request lines, bit n is line n |
| blk_mask_i | input | 8 | Per-line block bits, 1 suppresses the line |
| glob_en_i | input | 1 | Global interrupt permit |
| exc_lvl_i | input | 1 | Exception level active |
| err_lvl_i | input | 1 | Error level active |
| disp_mode_i | input | 2 | 0 single, 1 vectored, 2 table, 3 as single |
| ptr_valid_i | input | 1 | Table read response valid |
| ptr_data_i | input | 32 | Handler pointer returned by the table read |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| take_num_o | output | 3 | Number of the line being taken |
| redirect_o | output | 32 | Handler entry address, valid with take_o |
| ptr_rd_o | output | 1 | One-cycle table read request |
| ptr_addr_o | output | 32 | Table read address, valid with ptr_rd_o |

## Verification
Several properties are checked on every cycle:
- the single-cycle width of the take strobe and of the table read pulse;
- the silence of the block while the global permit is low or a level bit is set;
- the absence of a take while a table response is outstanding;
- that the encoder's choice is the highest set eligible bit.

Only the bench's scenarios can show the addresses themselves. These are the single entry point, the per-line vector arithmetic, the table pointer address, and the forwarding of the returned pointer. The bench sweeps every request pattern against several block patterns, gate settings and modes, and compares the chosen line and address against values it computes itself.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic [1:0] {
      DISP_SINGLE = 2'd0,
      DISP_VECTOR = 2'd1,
      DISP_TABLE  = 2'd2,
      DISP_ALIAS  = 2'd3
   } disp_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_COOL = 2'd2
   } disp_state_e;
endpackage

// File: rtl/irqd_qualify.sv
module irqd_qualify #(
   parameter int unsigned NUM_IRQ = 8
) (
   input  logic [NUM_IRQ-1:0] req_i,
   input  logic [NUM_IRQ-1:0] blk_i,
   input  logic               glob_en_i,
   input  logic               exc_lvl_i,
   input  logic               err_lvl_i,
   output logic [NUM_IRQ-1:0] elig_o
);
   logic gate_open;
   assign gate_open = glob_en_i & ~exc_lvl_i & ~err_lvl_i;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      assign elig_o[g] = req_i[g] & ~blk_i[g] & gate_open;
   end
endmodule

// File: rtl/irqd_prio.sv
module irqd_prio #(
   parameter int unsigned NUM_IRQ = 8,
   localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
   input  logic [NUM_IRQ-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (any_o) begin
         AST_PRIO_HIGHEST: assert (req_i[idx_o] && ((req_i >> idx_o) == NUM_IRQ'(1)))
            else $error("encoder did not pick the highest eligible line"); // R4
      end
   end
endmodule

// File: rtl/irqd_target.sv
module irqd_target #(
   parameter int unsigned NUM_IRQ    = 8,
   parameter int unsigned ADDR_W     = 32,
   parameter logic [31:0] KSEG_BASE  = 32'h8000_0000,
   parameter logic [31:0] SINGLE_OFF = 32'h0000_0180,
   parameter logic [31:0] VEC_STRIDE = 32'h0000_0100,
   parameter logic [31:0] TBL_BASE   = 32'h0000_0000,
   parameter int unsigned PTR_BYTES  = 4,
   localparam int unsigned IDX_W     = $clog2(NUM_IRQ)
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [1:0]        mode_i,
   output logic [ADDR_W-1:0] fixed_addr_o,
   output logic [ADDR_W-1:0] ptr_addr_o
);
   import irqd_pkg::*;

   logic [ADDR_W-1:0] slot;
   assign slot = ADDR_W'(idx_i) + ADDR_W'(1);

   always_comb begin
      if (disp_mode_e'(mode_i) == DISP_VECTOR)
         fixed_addr_o = ADDR_W'(KSEG_BASE) + slot * ADDR_W'(VEC_STRIDE);
      else
         fixed_addr_o = ADDR_W'(KSEG_BASE) + ADDR_W'(SINGLE_OFF);
   end

   assign ptr_addr_o = ADDR_W'(TBL_BASE) + slot * ADDR_W'(PTR_BYTES);
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit #(
   parameter int unsigned NUM_IRQ    = 8,
   parameter int unsigned ADDR_W     = 32,
   parameter logic [31:0] KSEG_BASE  = 32'h8000_0000,
   parameter logic [31:0] SINGLE_OFF = 32'h0000_0180,
   parameter logic [31:0] VEC_STRIDE = 32'h0000_0100,
   parameter logic [31:0] TBL_BASE   = 32'h0000_0000,
   parameter int unsigned PTR_BYTES  = 4,
   localparam int unsigned IDX_W     = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req_i,
   input  logic [NUM_IRQ-1:0] blk_mask_i,
   input  logic               glob_en_i,
   input  logic               exc_lvl_i,
   input  logic               err_lvl_i,
   input  logic [1:0]         disp_mode_i,
   input  logic               ptr_valid_i,
   input  logic [ADDR_W-1:0]  ptr_data_i,
   output logic               take_o,
   output logic [IDX_W-1:0]   take_num_o,
   output logic [ADDR_W-1:0]  redirect_o,
   output logic               ptr_rd_o,
   output logic [ADDR_W-1:0]  ptr_addr_o
);
   import irqd_pkg::*;

   if (NUM_IRQ < 2) begin : g_chk_num
      $error("NUM_IRQ must be at least 2");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_chk_aw
      $error("ADDR_W must lie in 8..32");
   end
   if (PTR_BYTES == 0) begin : g_chk_ptr
      $error("PTR_BYTES must be non-zero");
   end

   logic [NUM_IRQ-1:0] elig;
   logic               any_elig;
   logic [IDX_W-1:0]   win_idx;
   logic [ADDR_W-1:0]  fixed_addr;
   logic [ADDR_W-1:0]  tbl_addr;
   disp_state_e        st_q;

   irqd_qualify #(.NUM_IRQ(NUM_IRQ)) u_qualify (
      .req_i     (irq_req_i),
      .blk_i     (blk_mask_i),
      .glob_en_i (glob_en_i),
      .exc_lvl_i (exc_lvl_i),
      .err_lvl_i (err_lvl_i),
      .elig_o    (elig)
   );

   irqd_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
      .req_i (elig),
      .any_o (any_elig),
      .idx_o (win_idx)
   );

   irqd_target #(
      .NUM_IRQ    (NUM_IRQ),
      .ADDR_W     (ADDR_W),
      .KSEG_BASE  (KSEG_BASE),
      .SINGLE_OFF (SINGLE_OFF),
      .VEC_STRIDE (VEC_STRIDE),
      .TBL_BASE   (TBL_BASE),
      .PTR_BYTES  (PTR_BYTES)
   ) u_target (
      .idx_i        (win_idx),
      .mode_i       (disp_mode_i),
      .fixed_addr_o (fixed_addr),
      .ptr_addr_o   (tbl_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         take_o     <= 1'b0;
         take_num_o <= '0;
         redirect_o <= '0;
         ptr_rd_o   <= 1'b0;
         ptr_addr_o <= '0;
      end else begin
         take_o   <= 1'b0;
         ptr_rd_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (any_elig) begin
                  take_num_o <= win_idx;
                  if (disp_mode_e'(disp_mode_i) == DISP_TABLE) begin
                     ptr_rd_o   <= 1'b1;
                     ptr_addr_o <= tbl_addr;
                     st_q       <= ST_WAIT;
                  end else begin
                     take_o     <= 1'b1;
                     redirect_o <= fixed_addr;
                     st_q       <= ST_COOL;
                  end
               end
            end
            ST_WAIT: begin
               if (ptr_valid_i) begin
                  take_o     <= 1'b1;
                  redirect_o <= ptr_data_i;
                  st_q       <= ST_COOL;
               end
            end
            ST_COOL: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !take_o) else $error("take strobe longer than one cycle"); // R8
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rd_o |=> !ptr_rd_o) else $error("table read longer than one cycle"); // R7
   AST_PERMIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en_i && st_q == ST_IDLE) |=> (!take_o && !ptr_rd_o))
      else $error("activity with global permit low"); // R2
   AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_lvl_i || err_lvl_i) && st_q == ST_IDLE) |=> (!take_o && !ptr_rd_o))
      else $error("activity while a level bit is set"); // R3
   AST_WAIT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && !ptr_valid_i) |=> !take_o)
      else $error("take before table response"); // R7
   AST_BLOCKED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && (irq_req_i & ~blk_mask_i) == '0) |=> (!take_o && !ptr_rd_o))
      else $error("blocked line produced activity"); // R1
endmodule

// File: tb/irq_dispatch_unit_bench.sv
module irq_dispatch_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_req = '0;
   logic [7:0]  blk_mask = '0;
   logic        glob_en = 1'b0;
   logic        exc_lvl = 1'b0;
   logic        err_lvl = 1'b0;
   logic [1:0]  disp_mode = 2'd0;
   logic        ptr_valid = 1'b0;
   logic [31:0] ptr_data = '0;
   logic        take;
   logic [2:0]  take_num;
   logic [31:0] redirect;
   logic        ptr_rd;
   logic [31:0] ptr_addr;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_dispatch_unit u_irq_dispatch_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_req_i   (irq_req),
      .blk_mask_i  (blk_mask),
      .glob_en_i   (glob_en),
      .exc_lvl_i   (exc_lvl),
      .err_lvl_i   (err_lvl),
      .disp_mode_i (disp_mode),
      .ptr_valid_i (ptr_valid),
      .ptr_data_i  (ptr_data),
      .take_o      (take),
      .take_num_o  (take_num),
      .redirect_o  (redirect),
      .ptr_rd_o    (ptr_rd),
      .ptr_addr_o  (ptr_addr)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0]  msk;
      logic [7:0]  el;
      logic        gate;
      int          hi;
      logic [31:0] exp_addr;
      int          takes;
      logic        prev;
      logic [1:0]  modes [3];
      modes[0] = 2'd0; modes[1] = 2'd1; modes[2] = 2'd3;

      // R10: reset state
      tick();
      chk({31'd0, take}, 32'd0, "R10 take in reset");
      chk({31'd0, ptr_rd}, 32'd0, "R10 read in reset");
      tick();
      rst_n = 1'b1;
      tick();
      chk({31'd0, take}, 32'd0, "R10 take after reset");
      chk({31'd0, ptr_rd}, 32'd0, "R10 read after reset");

      // Sweep: R1 R2 R3 R4 R5 R6 R9 R11 and R8 release
      for (int m = 0; m < 3; m++) begin
         for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < 4; k++) begin
               for (int r = 0; r < 256; r++) begin
                  case (k)
                     0: msk = 8'h00;
                     1: msk = 8'hF0;
                     2: msk = 8'h0F;
                     default: msk = 8'(r * 29) ^ 8'hC3;
                  endcase
                  irq_req   = 8'(r);
                  blk_mask  = msk;
                  disp_mode = modes[m];
                  glob_en   = (g != 1);
                  exc_lvl   = (g == 2);
                  err_lvl   = (g == 3);
                  gate = glob_en && !exc_lvl && !err_lvl;
                  el   = gate ? (8'(r) & ~msk) : 8'h00;
                  hi   = -1;
                  for (int b = 0; b < 8; b++) if (el[b]) hi = b;
                  tick();
                  if (hi < 0) begin
                     chk({31'd0, take}, 32'd0,
                         !glob_en ? "R2 no take" : (!gate ? "R3 no take" : "R1 blocked"));
                  end else begin
                     chk({31'd0, take}, 32'd1, "R1/R9 take one edge after request");
                     chk({29'd0, take_num}, 32'(hi), "R4 highest line");
                     if (modes[m] == 2'd1) exp_addr = 32'h8000_0000 + 32'h100 * 32'(hi + 1);
                     else exp_addr = 32'h8000_0180;
                     chk(redirect, exp_addr,
                         modes[m] == 2'd1 ? "R6 vector" : (modes[m] == 2'd3 ? "R11 alias" : "R5 single"));
                  end
                  irq_req = 8'h00;
                  tick();
                  chk({31'd0, take}, 32'd0, "R8 strobe one cycle");
                  tick();
               end
            end
         end
      end

      // R8: held request gives alternating strobes
      glob_en = 1'b1; exc_lvl = 1'b0; err_lvl = 1'b0; blk_mask = 8'h00; disp_mode = 2'd0;
      irq_req = 8'h10;
      takes = 0; prev = 1'b0;
      for (int c = 0; c < 6; c++) begin
         tick();
         if (take) takes++;
         if (prev && take) chk(32'd1, 32'd0, "R8 consecutive strobes");
         prev = take;
      end
      chk(32'(takes), 32'd3, "R8 strobe count over six cycles");
      irq_req = 8'h00;
      tick(); tick();

      // R7: table mode for each line
      disp_mode = 2'd2;
      for (int n = 0; n < 8; n++) begin
         irq_req = 8'(1 << n);
         tick();
         chk({31'd0, ptr_rd}, 32'd1, "R7 read pulse");
         chk(ptr_addr, 32'(4 * (n + 1)), "R7 pointer address");
         chk({31'd0, take}, 32'd0, "R7 no take with read");
         irq_req = 8'h00;
         for (int w = 0; w < n % 3 + 1; w++) begin
            tick();
            chk({31'd0, take}, 32'd0, "R7 no take while waiting");
            chk({31'd0, ptr_rd}, 32'd0, "R7 read one cycle");
         end
         ptr_valid = 1'b1;
         ptr_data  = 32'hA000_0000 + 32'(n * 64);
         tick();
         ptr_valid = 1'b0;
         chk({31'd0, take}, 32'd1, "R7 take after response");
         chk(redirect, 32'hA000_0000 + 32'(n * 64), "R7 returned pointer");
         chk({29'd0, take_num}, 32'(n), "R7 line number");
         tick();
         chk({31'd0, take}, 32'd0, "R8 table strobe one cycle");
         tick();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule